// File: doc/BRIEF.md
# Paired-Clock Multi-Channel PWM Bank

This block generates up to sixteen pulse-width-modulated outputs from a small set of word registers. Channels are grouped two by two; each group shares one clock-configuration word that picks a tick source and divides it by a power of two. Every channel then applies its own (K+1) prescaler and runs a period counter. The output is at the active level while the count is below the active-cycle value and at the inactive level for the rest of the period. A bypass mode sends the pair's selected source, as a toggling level, straight to the pin.

Software reaches the block through a plain write strobe. Every write is taken in the cycle it is presented; there is no back-pressure and no valid/ready pair, because the port carries configuration, not a data stream. New channel or pair settings take effect at once, and the period in flight is dropped. When a channel is disabled, its output enable falls so that the pad can float, and its data pin is driven low. The two tick inputs are clock enables in the `clk` domain. No clock multiplexing cell is used.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every register is zero, and `pwm_oe` and `pwm_out` are all zero.
- R2: Pair word p sits at address 0x10+p and serves channels 2p and 2p+1. Bits 8:7 select the source: 0 is `osc_tick`, 1 is `bus_tick`, and 2 or 3 is no source. Bits 3:0 give the exponent m, and the selected ticks are divided by 2^min(m,8). An odd channel count leaves the last pair with a single channel.
- R3: Control word n sits at address 0x20+2n. Bits 7:0 hold K, and the pair tick is divided by K+1. Bit 8 is the active level.
- R4: Period word n sits at address 0x21+2n. Bits 31:16 hold the total E and bits 15:0 hold the active count A. The counter runs 0..E and then wraps, so a period lasts E+1 prescaled ticks.
- R5: An enabled channel that is not bypassed drives its active level while its counter is below A, and the opposite level otherwise.
- R6: Address 0x00 bit n enables channel n, and `pwm_oe[n]` follows it in the cycle after the write. When `pwm_oe[n]` is low, `pwm_out[n]` is low.
- R7: At address 0x01, bit n gates channel n. A channel's counters advance only when both its gate bit and its enable bit are set; otherwise they hold.
- R8: At address 0x01, bit n+16 bypasses channel n. An enabled, bypassed channel outputs a level that toggles on every selected source tick of its pair, taken before the divider, and its counters have no effect.
- R9: A write to a channel's control or period word clears that channel's prescaler and counter at the same edge. A write to a pair word clears that pair's divider.
- R10: Writes to unmapped addresses, and data bits for channels at or above NUM_CH, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator tick, one-cycle enable (source 0) |
| bus_tick | input | 1 | Bus clock tick, one-cycle enable (source 1) |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 8 | Word address |
| wr_data | input | 32 | Write data |
| pwm_out | output | NUM_CH | Channel output levels |
| pwm_oe | output | NUM_CH | Per-channel output enable (low = float) |

## Verification
The assertions check, on every cycle, four properties. A floating channel never drives high. The output enable matches the last enable write. Each counter stays within its total. A counter either holds or is cleared as the gate, enable and write rules require. The division chain of source, 2^m and K+1, the exact high and low fractions, the exponent clamp, the reserved source codes, bypass toggling and the single-channel last pair are shown only by the bench. It compares every cycle against a behavioural model and measures duty over whole periods.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CNT_W   = 16;
  localparam int PSC_W   = 8;
  localparam int MAX_EXP = 8;
  localparam int DIV_W   = MAX_EXP;

  localparam logic [7:0] ADDR_ENABLE    = 8'h00;
  localparam logic [7:0] ADDR_GATE      = 8'h01;
  localparam logic [7:0] ADDR_PAIR_BASE = 8'h10;
  localparam logic [7:0] ADDR_CHAN_BASE = 8'h20;

  localparam logic [1:0] SRC_OSC = 2'd0;
  localparam logic [1:0] SRC_BUS = 2'd1;

  typedef struct packed {
    logic [1:0] src;
    logic [3:0] exp;
  } pair_cfg_t;

  typedef struct packed {
    logic             pol;
    logic [PSC_W-1:0] presc;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] act;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_PAIRS = (NUM_CH + 1) / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [7:0]                wr_addr,
  input  logic [31:0]               wr_data,
  output logic [NUM_CH-1:0]         en_q,
  output logic [NUM_CH-1:0]         gate_q,
  output logic [NUM_CH-1:0]         byp_q,
  output pair_cfg_t [NUM_PAIRS-1:0] pair_cfg,
  output chan_cfg_t [NUM_CH-1:0]    chan_cfg,
  output logic [NUM_PAIRS-1:0]      pair_wr,
  output logic [NUM_CH-1:0]         chan_wr
);
  logic hit_en, hit_gate;
  assign hit_en   = wr_en && (wr_addr == ADDR_ENABLE);
  assign hit_gate = wr_en && (wr_addr == ADDR_GATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      gate_q <= '0;
      byp_q  <= '0;
    end else begin
      if (hit_en) en_q <= wr_data[NUM_CH-1:0];
      if (hit_gate) begin
        gate_q <= wr_data[NUM_CH-1:0];
        byp_q  <= wr_data[16 +: NUM_CH];
      end
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pair_wr[p] = wr_en && (wr_addr == ADDR_PAIR_BASE + 8'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pair_cfg[p] <= '0;
      else if (pair_wr[p]) begin
        pair_cfg[p].src <= wr_data[8:7];
        pair_cfg[p].exp <= wr_data[3:0];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic ctl_hit, per_hit;
    assign ctl_hit    = wr_en && (wr_addr == ADDR_CHAN_BASE + 8'(2 * c));
    assign per_hit    = wr_en && (wr_addr == ADDR_CHAN_BASE + 8'(2 * c + 1));
    assign chan_wr[c] = ctl_hit || per_hit;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chan_cfg[c] <= '0;
      else begin
        if (ctl_hit) begin
          chan_cfg[c].presc <= wr_data[PSC_W-1:0];
          chan_cfg[c].pol   <= wr_data[8];
        end
        if (per_hit) begin
          chan_cfg[c].total <= wr_data[31:16];
          chan_cfg[c].act   <= wr_data[15:0];
        end
      end
    end
  end
endmodule

// File: rtl/pwm_pair_clk.sv
module pwm_pair_clk
  import pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      osc_tick,
  input  logic      bus_tick,
  input  pair_cfg_t cfg,
  input  logic      restart,
  output logic      tick,
  output logic      phase
);
  logic             src_tick;
  logic [3:0]       exp_eff;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] dcnt;

  always_comb begin
    case (cfg.src)
      SRC_OSC: src_tick = osc_tick;
      SRC_BUS: src_tick = bus_tick;
      default: src_tick = 1'b0;
    endcase
  end

  assign exp_eff = (cfg.exp > 4'(MAX_EXP)) ? 4'(MAX_EXP) : cfg.exp;
  assign span    = ((DIV_W+1)'(1) << exp_eff) - (DIV_W+1)'(1);
  assign tick    = src_tick && ({1'b0, dcnt} == span);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt  <= '0;
      phase <= 1'b0;
    end else begin
      phase <= phase ^ src_tick;
      if (restart)       dcnt <= '0;
      else if (src_tick) dcnt <= tick ? '0 : dcnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_tick,
  input  logic             pair_phase,
  input  logic             enable,
  input  logic             gate,
  input  logic             bypass,
  input  chan_cfg_t        cfg,
  input  logic             restart,
  output logic             out,
  output logic             oe,
  output logic [CNT_W-1:0] cnt
);
  logic [PSC_W-1:0] psc;
  logic             run;

  assign run = enable && gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc <= '0;
      cnt <= '0;
    end else if (restart) begin
      psc <= '0;
      cnt <= '0;
    end else if (pair_tick && run) begin
      if (psc == cfg.presc) begin
        psc <= '0;
        cnt <= (cnt == cfg.total) ? '0 : cnt + 1'b1;
      end else begin
        psc <= psc + 1'b1;
      end
    end
  end

  always_comb begin
    oe = enable;
    if (!enable)     out = 1'b0;
    else if (bypass) out = pair_phase;
    else             out = (cnt < cfg.act) ? cfg.pol : ~cfg.pol;
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              bus_tick,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_oe
);
  localparam int NUM_PAIRS = (NUM_CH + 1) / 2;

  logic [NUM_CH-1:0]             en_q, gate_q, byp_q, chan_wr;
  logic [NUM_PAIRS-1:0]          pair_wr, pair_tick, pair_phase;
  pair_cfg_t [NUM_PAIRS-1:0]     pair_cfg;
  chan_cfg_t [NUM_CH-1:0]        chan_cfg;
  logic [NUM_CH-1:0][CNT_W-1:0]  chan_cnt;

  pwm_regfile #(.NUM_CH(NUM_CH), .NUM_PAIRS(NUM_PAIRS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_q(en_q), .gate_q(gate_q), .byp_q(byp_q), .pair_cfg(pair_cfg),
    .chan_cfg(chan_cfg), .pair_wr(pair_wr), .chan_wr(chan_wr)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    pwm_pair_clk u_clk (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_tick(bus_tick),
      .cfg(pair_cfg[p]), .restart(pair_wr[p]),
      .tick(pair_tick[p]), .phase(pair_phase[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    localparam int P = c / 2;
    pwm_chan u_chan (
      .clk(clk), .rst_n(rst_n), .pair_tick(pair_tick[P]), .pair_phase(pair_phase[P]),
      .enable(en_q[c]), .gate(gate_q[c]), .bypass(byp_q[c]), .cfg(chan_cfg[c]),
      .restart(chan_wr[c]), .out(pwm_out[c]), .oe(pwm_oe[c]), .cnt(chan_cnt[c])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [7:0]                  wr_addr,
  input logic [31:0]                 wr_data,
  input logic [NUM_CH-1:0]           pwm_out,
  input logic [NUM_CH-1:0]           pwm_oe,
  input logic [NUM_CH-1:0]           en_q,
  input logic [NUM_CH-1:0]           gate_q,
  input chan_cfg_t [NUM_CH-1:0]      chan_cfg,
  input logic [NUM_CH-1:0][CNT_W-1:0] chan_cnt
);
  AST_FLOAT_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~pwm_oe) == '0); // R6

  AST_OE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_ENABLE) |=> (pwm_oe == $past(wr_data[NUM_CH-1:0]))); // R6

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic own_wr;
    assign own_wr = wr_en && ((wr_addr == ADDR_CHAN_BASE + 8'(2 * c)) ||
                              (wr_addr == ADDR_CHAN_BASE + 8'(2 * c + 1)));

    AST_CNT_WITHIN_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      chan_cnt[c] <= chan_cfg[c].total); // R4

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      own_wr |=> (chan_cnt[c] == '0)); // R9

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!(en_q[c] && gate_q[c]) && !own_wr) |=> $stable(chan_cnt[c])); // R7
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pwm_out(pwm_out), .pwm_oe(pwm_oe), .en_q(en_q), .gate_q(gate_q),
  .chan_cfg(chan_cfg), .chan_cnt(chan_cnt)
);

// File: tb/pwm_bank_test.sv
`timescale 1ns/1ps
module pwm_bank_test;
  localparam int NCH = 3;
  localparam int NP  = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            osc_tick = 1'b0;
  logic            bus_tick = 1'b1;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [NCH-1:0]  pwm_out, pwm_oe;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_bank #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_tick(bus_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  // oscillator ticks: one cycle in three
  int ocnt = 0;
  always @(negedge clk) begin
    if (!rst_n) ocnt = 0;
    else ocnt = (ocnt == 2) ? 0 : ocnt + 1;
    osc_tick = rst_n && (ocnt == 0);
  end

  // behavioural reference model
  int m_src[NP], m_exp[NP], m_div[NP], m_ph[NP];
  int m_k[NCH], m_pol[NCH], m_e[NCH], m_a[NCH], m_pc[NCH], m_cnt[NCH];
  int m_en[NCH], m_gate[NCH], m_byp[NCH];

  always @(posedge clk) begin
    int pt[NP];
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_src[p]=0; m_exp[p]=0; m_div[p]=0; m_ph[p]=0; end
      for (int c = 0; c < NCH; c++) begin
        m_k[c]=0; m_pol[c]=0; m_e[c]=0; m_a[c]=0; m_pc[c]=0; m_cnt[c]=0;
        m_en[c]=0; m_gate[c]=0; m_byp[c]=0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        int st, me;
        st = (m_src[p] == 0) ? int'(osc_tick) : (m_src[p] == 1) ? int'(bus_tick) : 0;
        me = (m_exp[p] > 8) ? 8 : m_exp[p];
        pt[p] = (st != 0 && m_div[p] == (1 << me) - 1) ? 1 : 0;
        if (st != 0) begin
          m_div[p] = (pt[p] != 0) ? 0 : m_div[p] + 1;
          m_ph[p]  = 1 - m_ph[p];
        end
      end
      for (int c = 0; c < NCH; c++) begin
        if (pt[c/2] != 0 && m_en[c] != 0 && m_gate[c] != 0) begin
          if (m_pc[c] == m_k[c]) begin
            m_pc[c] = 0;
            m_cnt[c] = (m_cnt[c] == m_e[c]) ? 0 : m_cnt[c] + 1;
          end else m_pc[c] = m_pc[c] + 1;
        end
      end
      if (wr_en) begin
        int a;
        a = int'(wr_addr);
        if (a == 0) for (int c = 0; c < NCH; c++) m_en[c] = int'(wr_data[c]);
        else if (a == 1) for (int c = 0; c < NCH; c++) begin
          m_gate[c] = int'(wr_data[c]);
          m_byp[c]  = int'(wr_data[16 + c]);
        end
        else if (a >= 16 && a < 16 + NP) begin
          m_src[a-16] = int'(wr_data[8:7]);
          m_exp[a-16] = int'(wr_data[3:0]);
          m_div[a-16] = 0;
        end
        else if (a >= 32 && a < 32 + 2 * NCH) begin
          int c;
          c = (a - 32) / 2;
          if (a % 2 == 0) begin m_k[c] = int'(wr_data[7:0]); m_pol[c] = int'(wr_data[8]); end
          else begin m_e[c] = int'(wr_data[31:16]); m_a[c] = int'(wr_data[15:0]); end
          m_pc[c] = 0;
          m_cnt[c] = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model: R5 R6 R8
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++) begin
        int eo, ev;
        eo = m_en[c];
        if (eo == 0) ev = 0;
        else if (m_byp[c] != 0) ev = m_ph[c/2];
        else ev = (m_cnt[c] < m_a[c]) ? m_pol[c] : 1 - m_pol[c];
        chk(int'(pwm_oe[c]) == eo && int'(pwm_out[c]) == ev, "R5 R6 R8 model",
            int'({pwm_oe[c], pwm_out[c]}), eo * 2 + ev);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(input int ch, input int n, output int hits);
    hits = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[ch]) hits++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int h;
    logic prev;
    bit ok;
    repeat (3) @(negedge clk);
    chk(pwm_oe == '0 && pwm_out == '0, "R1 reset", int'({pwm_oe, pwm_out}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm_oe == '0 && pwm_out == '0, "R1 after release", int'({pwm_oe, pwm_out}), 0);

    // pair 0 on bus ticks, no division
    wr(8'h10, 32'h0000_0080);
    wr(8'h20, 32'h0000_0100);              // ch0 K=0, active high
    wr(8'h21, (32'd3 << 16) | 32'd1);      // ch0 E=3 A=1
    wr(8'h22, 32'h0000_0002);              // ch1 K=2, active low
    wr(8'h23, (32'd1 << 16) | 32'd1);      // ch1 E=1 A=1
    wr(8'h01, 32'h0000_0003);
    wr(8'h00, 32'h0000_0003);
    chk(pwm_oe == 3'b011, "R6 enable", int'(pwm_oe), 3);
    count_high(0, 8, h);
    chk(h == 2, "R4 R5 ch0 duty", h, 2);
    count_high(1, 12, h);
    chk(h == 6, "R3 ch1 prescale and polarity", h, 6);

    // divide pair by 4
    wr(8'h10, 32'h0000_0082);
    idle(30);
    count_high(0, 32, h);
    chk(h == 8, "R2 pair divider ch0", h, 8);
    count_high(1, 24, h);
    chk(h == 12, "R2 shared divider ch1", h, 12);

    // gate ch0 off: counter holds
    wr(8'h01, 32'h0000_0002);
    prev = pwm_out[0];
    ok = 1;
    repeat (10) begin @(negedge clk); if (pwm_out[0] != prev) ok = 0; end
    chk(ok, "R7 gated channel holds", int'(pwm_out[0]), int'(prev));

    // bypass ch0: toggles every bus tick
    wr(8'h01, 32'h0001_0002);
    ok = 1;
    prev = pwm_out[0];
    repeat (6) begin @(negedge clk); if (pwm_out[0] == prev) ok = 0; prev = pwm_out[0]; end
    chk(ok, "R8 bypass toggles", int'(pwm_out[0]), int'(!prev));

    // immediate restart on control write
    wr(8'h22, 32'h0000_0000);
    chk(pwm_out[1] == 1'b0, "R9 restart low-active", int'(pwm_out[1]), 0);
    wr(8'h22, 32'h0000_0100);
    chk(pwm_out[1] == 1'b1, "R9 restart high-active", int'(pwm_out[1]), 1);

    // disable ch0
    wr(8'h00, 32'h0000_0002);
    chk(pwm_oe[0] == 1'b0 && pwm_out[0] == 1'b0, "R6 disabled floats low",
        int'({pwm_oe[0], pwm_out[0]}), 0);

    // ignored writes
    wr(8'h05, 32'hFFFF_FFFF);
    wr(8'h26, 32'h0000_01FF);
    wr(8'h12, 32'h0000_0080);
    wr(8'h00, 32'h0000_000A);
    chk(pwm_oe == 3'b010, "R10 ignored bits and addresses", int'(pwm_oe), 2);

    // odd last pair: ch2 on oscillator ticks
    wr(8'h11, 32'h0000_0000);
    wr(8'h24, 32'h0000_0100);
    wr(8'h25, (32'd1 << 16) | 32'd1);
    wr(8'h01, 32'h0001_0006);
    wr(8'h00, 32'h0000_0006);
    idle(12);
    count_high(2, 12, h);
    chk(h == 6, "R2 oscillator source single-channel pair", h, 6);

    // reserved source code: no ticks
    wr(8'h11, 32'h0000_0100);
    prev = pwm_out[2];
    ok = 1;
    repeat (12) begin @(negedge clk); if (pwm_out[2] != prev) ok = 0; end
    chk(ok, "R2 reserved source stops", int'(pwm_out[2]), int'(prev));

    // exponent clamp: 15 behaves as 8
    wr(8'h10, 32'h0000_008F);
    idle(600);
    count_high(1, 512, h);
    chk(h == 256, "R2 exponent clamp", h, 256);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule